// File: doc/BRIEF.md
# Clock-Pair Enable Configuration Target on a Two-Wire Bus

This block is a target on a two-wire serial bus (I2C). It holds a small bank of 8-bit configuration registers and turns two of them into an enable vector for a bank of differential clock output pairs. SCL and SDA are oversampled by a much faster system clock. Each line passes through a synchroniser and a majority-free agreement filter before any edge is decoded.

Access has no register pointer. A write addressed to the device carries two leading bytes, a command code and a byte count. Both are acknowledged and then discarded. The data bytes that follow fill the registers from register 0 upward. A read first returns a count byte and then the registers from register 0 upward. Any start condition restarts decoding from the address byte.

Top module: `clk_cfg_i2c_slave`

## Requirements
- R1: The address byte 0xD2 (7-bit address 0x69, R/W bit 0) and the address byte 0xD3 (R/W bit 1) are both acknowledged. Any other address byte gets no acknowledge, and later bytes are not acknowledged until the next start.
- R2: In a write, the first two bytes after the address (command code, then byte count) are acknowledged. Neither changes any register.
- R3: Write data bytes land in registers 0, 1, 2, … in arrival order, and each one is acknowledged. A stop after any complete byte keeps every byte written so far.
- R4: A write data byte that arrives after the last register is not acknowledged and changes no register.
- R5: A read returns the byte count 6 first and then registers 0 to 5 in order, MSB first. The host acknowledges each byte. A read changes no register.
- R6: A host NACK during a read releases SDA. Further clocked bits of that transfer read as 1.
- R7: After reset, registers 0 to 4 hold 0xFF and register 5 holds 0x06.
- R8: Enable bit p is 1 when the pair is enabled. Pairs 0..7 come from register 0 bits 7..0 (bit 7 drives pair 0). Pair 8 comes from register 1 bit 7 and pair 9 from register 1 bit 6.
- R9: A repeated start aborts the current transfer, decodes a fresh address byte, and sends the next data access back to register 0.
- R10: An SCL or SDA pulse shorter than FILT_LEN system clocks is ignored. It causes no extra bit, no false start and no false stop.
- R11: The readback bus carries register k on bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | When 1, the open-drain driver pulls SDA low |
| reg_rd_o | output | 48 | All configuration registers, register k at bits 8k+7:8k |
| clk_en_o | output | 10 | Per-pair output enable, 1 = enabled |

## Verification
The bench builds the block with its defaults: six registers, ten pairs, a three-sample filter and device address 0x69. It drives SCL with a quarter period of 16 system clocks. That is far faster than a real 100 kbit/s bus, but every SCL phase still outlasts the six-cycle input path. Because of this, whole write-then-read rounds, the overflow byte, the repeated starts and the single-cycle glitches on both lines all fit in a short run. The checks compare the readback bus, the enable vector and the bytes read over the bus against a register model that the bench keeps from its own writes.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } phase_e;

  // Power-up contents: last register differs from the rest
  function automatic logic [7:0] reg_init(input int k, input int n);
    return (k == n - 1) ? 8'h06 : 8'hFF;
  endfunction

endpackage

// File: rtl/i2c_in_filter.sv
module i2c_in_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] win_q;
  logic                out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[1]};
      // change only when the whole window agrees
      if (&win_q)       out_q <= 1'b1;
      else if (~|win_q) out_q <= 1'b0;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NUM_REGS  = 6,
  parameter int NUM_PAIRS = 10,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      wr_sel_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [NUM_PAIRS-1:0]  en_o
);

  import cfg_i2c_pkg::*;

  logic [NUM_REGS-1:0][7:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= reg_init(k, NUM_REGS);
    end else if (wr_en_i) begin
      for (int k = 0; k < NUM_REGS; k++)
        if (wr_sel_i == SEL_W'(k)) regs_q[k] <= wr_data_i;
    end
  end

  assign regs_o = regs_q;

  // pair p sits MSB-first inside register p/8
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign en_o[p] = regs_q[p / 8][7 - (p % 8)];
  end

endmodule

// File: rtl/clk_cfg_i2c_slave.sv
module clk_cfg_i2c_slave #(
  parameter int         NUM_REGS  = 6,
  parameter int         NUM_PAIRS = 10,
  parameter int         FILT_LEN  = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h69
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] reg_rd_o,
  output logic [NUM_PAIRS-1:0]  clk_en_o
);

  import cfg_i2c_pkg::*;

  localparam int IDX_W = $clog2(NUM_REGS + 3);
  localparam int SEL_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] WR_FIRST = IDX_W'(2);
  localparam logic [IDX_W-1:0] WR_END   = IDX_W'(2 + NUM_REGS);
  localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(NUM_REGS);
  localparam logic [7:0]       COUNT_B  = 8'(NUM_REGS);

  // ---- input conditioning
  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_in_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  // ---- sequencer state
  phase_e           state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             addr_ph_q, is_read_q, pull_q;

  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [7:0]       tx_byte;

  assign wr_en  = (state_q == ST_RX) && scl_fall && (bit_cnt_q == 4'd8) && !addr_ph_q &&
                  (idx_q >= WR_FIRST) && (idx_q < WR_END);
  assign wr_sel = SEL_W'(idx_q - WR_FIRST);

  always_comb begin
    tx_byte = 8'hFF;
    if (idx_q == '0) tx_byte = COUNT_B;
    else
      for (int k = 0; k < NUM_REGS; k++)
        if (idx_q == IDX_W'(k + 1)) tx_byte = reg_rd_o[k*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      addr_ph_q <= 1'b0;
      is_read_q <= 1'b0;
      pull_q    <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_RX;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      addr_ph_q <= 1'b1;
      is_read_q <= 1'b0;
      pull_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            sh_q      <= {sh_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            if (addr_ph_q) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                pull_q    <= 1'b1;
                is_read_q <= sh_q[0];
                addr_ph_q <= 1'b0;
                state_q   <= ST_RX_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (idx_q < WR_END) begin
              pull_q  <= 1'b1;
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_RX_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (is_read_q) begin
              sh_q    <= tx_byte;
              pull_q  <= ~tx_byte[7];
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_TX;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              pull_q  <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              sh_q   <= {sh_q[6:0], 1'b1};
              pull_q <= ~sh_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_f) begin
            state_q <= ST_IDLE;           // host NACK
          end else if (scl_fall) begin
            bit_cnt_q <= '0;
            if (idx_q <= RD_LAST) begin
              sh_q    <= tx_byte;
              pull_q  <= ~tx_byte[7];
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  logic in_idle, in_rx;
  assign in_idle = (state_q == ST_IDLE);
  assign in_rx   = (state_q == ST_RX);

  cfg_regfile #(.NUM_REGS(NUM_REGS), .NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(sh_q),
    .regs_o   (reg_rd_o),
    .en_o     (clk_en_o)
  );

endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker #(
  parameter int REG_BITS = 48,
  parameter int IDX_W    = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_f,
  input logic                start_det,
  input logic                in_idle,
  input logic                in_rx,
  input logic                is_read,
  input logic [IDX_W-1:0]    idx_q,
  input logic                sda_pull_o,
  input logic [REG_BITS-1:0] reg_rd_o
);

  AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_f));  // R1

  AST_WRITE_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o != $past(reg_rd_o)) |-> sda_pull_o);  // R3

  AST_READ_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_read |=> $stable(reg_rd_o));  // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_idle |-> !sda_pull_o);  // R6

  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (in_rx && idx_q == '0 && !sda_pull_o));  // R9

endmodule

bind clk_cfg_i2c_slave cfg_i2c_checker #(
  .REG_BITS(NUM_REGS * 8),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f     (scl_f),
  .start_det (start_det),
  .in_idle   (in_idle),
  .in_rx     (in_rx),
  .is_read   (is_read_q),
  .idx_q     (idx_q),
  .sda_pull_o(sda_pull_o),
  .reg_rd_o  (reg_rd_o)
);

// File: tb/tb_clk_cfg_i2c_slave.sv
`timescale 1ns/1ps
module tb_clk_cfg_i2c_slave;

  localparam int NREG = 6;
  localparam int NPR  = 10;
  localparam int Q    = 16;
  localparam logic [7:0] AW = 8'hD2;
  localparam logic [7:0] AR = 8'hD3;

  // [55:48] data byte count, [47:40] first data byte ... [7:0] sixth
  localparam logic [55:0] VEC [4] = '{
    {8'd6, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h0F, 8'hF0},
    {8'd2, 8'h00, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'd4, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic sda_pull, sda_line;
  logic [NREG*8-1:0] rd;
  logic [NPR-1:0]    en;

  assign sda_line = sda_h & ~sda_pull;

  always #2 clk = ~clk;

  clk_cfg_i2c_slave dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_pull_o(sda_pull),
    .reg_rd_o  (rd),
    .clk_en_o  (en)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mdl [NREG];

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] mdl_flat();
    logic [NREG*8-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = mdl[k];
    return f;
  endfunction

  function automatic logic [NPR-1:0] mdl_en();
    logic [NPR-1:0] e;
    for (int p = 0; p < NPR; p++) e[p] = mdl[p/8][7 - (p%8)];
    return e;
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1; wait_q(); scl = 1; wait_q(); sda_h = 0; wait_q(); scl = 0; wait_q();
  endtask

  task automatic bus_stop();
    sda_h = 0; wait_q(); scl = 1; wait_q(); sda_h = 1; wait_q(); wait_q();
  endtask

  task automatic put_bit(input logic b, input bit gl);
    sda_h = b; wait_q();
    if (gl) begin scl = 1; @(negedge clk); scl = 0; wait_q(); end
    scl = 1; wait_q();
    if (gl) begin sda_h = ~b; @(negedge clk); sda_h = b; end
    wait_q(); scl = 0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1; wait_q(); scl = 1; wait_q(); b = sda_line; wait_q(); scl = 0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, input bit gl, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], gl);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~host_ack, 1'b0);
  endtask

  task automatic write_head(input logic [7:0] addr);
    logic a;
    bus_start();
    send_byte(addr, 0, a);  chk(a === 1'b1, "R1 write address ack", a, 1);
    send_byte(8'h5A, 0, a); chk(a === 1'b1, "R2 command ack", a, 1);
    send_byte(8'h99, 0, a); chk(a === 1'b1, "R2 count ack", a, 1);
  endtask

  task automatic send_data(input logic [7:0] d, input int k, input bit gl);
    logic a;
    send_byte(d, gl, a);
    chk(a === 1'b1, "R3 data ack", a, 1);
    mdl[k] = d;
  endtask

  task automatic check_regs(input string req);
    @(negedge clk);
    chk(rd === mdl_flat(), req, rd, mdl_flat());
    chk(en === mdl_en(), "R8 enable map", en, mdl_en());
  endtask

  task automatic read_all();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(AR, 0, a); chk(a === 1'b1, "R1 read address ack", a, 1);
    recv_byte(1, d); chk(d === 8'd6, "R5 byte count", d, 6);
    for (int k = 0; k < NREG; k++) begin
      recv_byte(k != NREG - 1, d);
      chk(d === mdl[k], "R5 read register", d, mdl[k]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int k = 0; k < NREG; k++) mdl[k] = (k == NREG - 1) ? 8'h06 : 8'hFF;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R7 R11 reset contents
    chk(rd === 48'h06FF_FFFF_FFFF, "R7 R11 reset regs", rd, 48'h06FF_FFFF_FFFF);
    chk(en === 10'h3FF, "R8 reset enables", en, 10'h3FF);
    chk(sda_pull === 1'b0, "R6 released at reset", sda_pull, 0);
    read_all();

    // vector table: partial and full writes, each read back
    for (int v = 0; v < 4; v++) begin
      write_head(AW);
      for (int k = 0; k < int'(VEC[v][55:48]); k++) send_data(VEC[v][47 - 8*k -: 8], k, 0);
      bus_stop();
      check_regs("R3 R11 write vector");
      read_all();
    end

    // R4 overflow byte
    write_head(AW);
    for (int k = 0; k < NREG; k++) send_data(8'h10 + 8'(k), k, 0);
    send_byte(8'hEE, 0, a);
    chk(a === 1'b0, "R4 overflow no ack", a, 0);
    bus_stop();
    check_regs("R4 overflow discarded");

    // R1 foreign address
    bus_start();
    send_byte(8'hA0, 0, a); chk(a === 1'b0, "R1 foreign address nack", a, 0);
    send_byte(8'h00, 0, a); chk(a === 1'b0, "R1 ignored after nack", a, 0);
    send_byte(8'h00, 0, a);
    bus_stop();
    check_regs("R1 foreign write no effect");

    // R6 host NACK mid-read
    bus_start();
    send_byte(AR, 0, a);
    recv_byte(1, d);
    recv_byte(0, d); chk(d === mdl[0], "R6 first register", d, mdl[0]);
    wait_q();
    chk(sda_pull === 1'b0, "R6 sda released", sda_pull, 0);
    recv_byte(0, d); chk(d === 8'hFF, "R6 bus floats high", d, 8'hFF);
    bus_stop();

    // R9 repeated start inside a write
    write_head(AW);
    send_data(8'h11, 0, 0);
    send_data(8'h44, 1, 0);
    write_head(AW);
    send_data(8'h22, 0, 0);
    bus_stop();
    check_regs("R9 restart at register 0");

    // R9 repeated start from write into read
    write_head(AW);
    send_data(8'h55, 0, 0);
    bus_start();
    send_byte(AR, 0, a); chk(a === 1'b1, "R9 read after restart ack", a, 1);
    recv_byte(1, d); chk(d === 8'd6, "R9 count after restart", d, 6);
    recv_byte(0, d); chk(d === 8'h55, "R9 register 0 after restart", d, 8'h55);
    bus_stop();

    // R10 single-cycle glitches on both lines
    write_head(AW);
    send_data(8'hB6, 0, 1);
    send_data(8'h49, 1, 1);
    bus_stop();
    check_regs("R10 glitches filtered");
    read_all();

    finish_run();
  end

endmodule